// File: doc/BRIEF.md
# Two-Level Residue-to-Binary Converter

This block rebuilds a binary integer from its four residues in a residue number system whose channel moduli are 2^(N-1)-1, 2^(N+1)-1, 2^N-1 and 2^N. The combined range is M = (2^(N-1)-1)(2^(N+1)-1)(2^N-1)·2^N, which is roughly 4N bits. It sits at the back end of a residue arithmetic datapath and turns each finished residue tuple into an ordinary binary word.

The conversion runs as two mixed-radix passes. The first pass merges the three channels of the form 2^k-1 into one value X1 modulo their product P. All of its subtractions and constant multiplications reduce with end-around carry, and it forms only the mixed-radix digits that the final sum needs. The second pass pairs X1 with the residue modulo 2^N. That modulus is a power of two, so its reduction just keeps the low N bits. The result is X = X1 + P·(((r_d − X1)·P⁻¹) mod 2^N). The inverse constants are computed from N during elaboration. N must be even and at least 4 so that the four moduli are pairwise coprime.

There is one register stage after each pass, so a result appears exactly two cycles after its inputs. The block accepts a new tuple on every cycle.

Top module: `rns4_to_bin`

## Requirements
- R1: While rst_ni is low, and after it is released, valid_o is 0 and bin_o is 0 until a sample has gone through. If reset is asserted while a sample is in flight, that sample never produces a valid_o.
- R2: valid_o is 1 in exactly those cycles that come two clock edges after a cycle in which valid_i was 1.
- R3: On a valid output, bin_o mod (2^(N-1)-1) equals res_a_i of the matching input.
- R4: On a valid output, bin_o mod (2^(N+1)-1) equals res_b_i of the matching input.
- R5: On a valid output, bin_o mod (2^N-1) equals res_c_i of the matching input.
- R6: On a valid output, bin_o[N-1:0] equals res_d_i of the matching input.
- R7: Every valid bin_o lies in the range [0, M).
- R8: On res_a_i, res_b_i and res_c_i, the all-ones pattern is taken as zero. For N=4, the tuple (7,31,15,0) gives 0 and the tuple (7,1,1,1) gives 7441.
- R9: Inputs presented on consecutive cycles each give their own correct result on consecutive cycles, with no stall.
- R10: While valid_o is 0, bin_o keeps the value of the last valid result.
- R11: For N=4, every X in [0, 52080) converts back to X when its residues (X mod 7, X mod 31, X mod 15, X mod 16) are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | The input residues are valid this cycle |
| res_a_i | input | N-1 | Residue modulo 2^(N-1)-1 |
| res_b_i | input | N+1 | Residue modulo 2^(N+1)-1 |
| res_c_i | input | N | Residue modulo 2^N-1 |
| res_d_i | input | N | Residue modulo 2^N |
| valid_o | output | 1 | bin_o holds a new result this cycle |
| bin_o | output | 4N | Reconstructed binary value |

## Verification
The two functions that can fall in the same cycle are the first-level merge of a new tuple and the second-level recombination of the tuple before it. They meet in the same cycle whenever inputs arrive back to back. The exhaustive sweep provokes this by applying a new tuple on every cycle for the whole 52080-value range. It judges each output against the index applied exactly two cycles earlier, so a stage that leaked data between neighbouring samples would show up as a mismatch. Isolated single-sample vectors with idle gaps around them then confirm that the output holds and that valid_o drops between samples.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  // Modular inverse by extended Euclid; elaboration-time only.
  function automatic longint mod_inv(longint a, longint m);
    longint t, nt, r, nr, q, tmp;
    t  = 0;
    nt = 1;
    r  = m;
    nr = a % m;
    while (nr != 0) begin
      q   = r / nr;
      tmp = t - q * nt;
      t   = nt;
      nt  = tmp;
      tmp = r - q * nr;
      r   = nr;
      nr  = tmp;
    end
    if (t < 0) t = t + m;
    return t;
  endfunction
endpackage

// File: rtl/rbc_fold.sv
// Reduces a W-bit value modulo 2^K-1 by summing K-bit chunks with end-around carry.
module rbc_fold #(
  parameter int K = 4,
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  output logic [K-1:0] y_o
);
  localparam int NCH = (W + K - 1) / K;
  localparam int PW  = NCH * K;
  localparam int AW  = K + $clog2(NCH + 1) + 2;

  logic [PW-1:0] ap;
  logic [AW-1:0] acc;

  assign ap = PW'(a_i);

  always_comb begin
    acc = '0;
    for (int i = 0; i < NCH; i++) acc = acc + AW'(ap[i*K +: K]);
    for (int j = 0; j < 3; j++) acc = AW'(acc[K-1:0]) + (acc >> K);
  end

  assign y_o = (acc[K-1:0] == {K{1'b1}}) ? '0 : acc[K-1:0];
endmodule

// File: rtl/rbc_sub.sv
// (a - b) mod 2^K-1 via one's-complement add.
module rbc_sub #(
  parameter int K = 4
) (
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  output logic [K-1:0] y_o
);
  logic [K:0] s;
  assign s = {1'b0, a_i} + {1'b0, ~b_i};

  rbc_fold #(.K(K), .W(K + 1)) u_fold (.a_i(s), .y_o(y_o));
endmodule

// File: rtl/rbc_mulc.sv
// (a * C) mod 2^K-1 for a constant C.
module rbc_mulc #(
  parameter int          K  = 4,
  parameter int          WA = 4,
  parameter longint      C  = 1
) (
  input  logic [WA-1:0] a_i,
  output logic [K-1:0]  y_o
);
  localparam int PW = WA + K;
  logic [PW-1:0] p;
  assign p = PW'(a_i) * PW'(C);

  rbc_fold #(.K(K), .W(PW)) u_fold (.a_i(p), .y_o(y_o));
endmodule

// File: rtl/rbc_level1.sv
// Three-moduli mixed-radix stage over the 2^k-1 channels; only the digits the sum needs.
module rbc_level1 #(
  parameter int N = 4
) (
  input  logic [N-2:0]   ra_i,
  input  logic [N:0]     rb_i,
  input  logic [N-1:0]   rc_i,
  output logic [3*N-1:0] x1_o
);
  import rbc_pkg::*;
  localparam int     K1  = N - 1;
  localparam int     K2  = N + 1;
  localparam int     K3  = N;
  localparam int     XW  = 3 * N;
  localparam longint M1  = (longint'(1) << K1) - 1;
  localparam longint M2  = (longint'(1) << K2) - 1;
  localparam longint M3  = (longint'(1) << K3) - 1;
  localparam longint C2  = mod_inv(M1 % M2, M2);
  localparam longint C3A = M1 % M3;
  localparam longint C3  = mod_inv((M1 * M2) % M3, M3);

  logic [K1-1:0] v1;
  logic [K2-1:0] d2, v2;
  logic [K3-1:0] d3, t3, e3, v3;

  rbc_fold #(.K(K1), .W(K1)) u_v1 (.a_i(ra_i), .y_o(v1));

  rbc_sub  #(.K(K2))                    u_d2 (.a_i(rb_i), .b_i(K2'(v1)), .y_o(d2));
  rbc_mulc #(.K(K2), .WA(K2), .C(C2))   u_v2 (.a_i(d2), .y_o(v2));

  rbc_sub  #(.K(K3))                    u_d3 (.a_i(rc_i), .b_i(K3'(v1)), .y_o(d3));
  rbc_mulc #(.K(K3), .WA(K2), .C(C3A))  u_t3 (.a_i(v2), .y_o(t3));
  rbc_sub  #(.K(K3))                    u_e3 (.a_i(d3), .b_i(t3), .y_o(e3));
  rbc_mulc #(.K(K3), .WA(K3), .C(C3))   u_v3 (.a_i(e3), .y_o(v3));

  assign x1_o = XW'(v1) + XW'(M1) * XW'(v2) + XW'(M1 * M2) * XW'(v3);
endmodule

// File: rtl/rbc_level2.sv
// Two-moduli stage {P, 2^N}: mod 2^N is truncation.
module rbc_level2 #(
  parameter int     N  = 4,
  parameter longint P  = 3255,
  parameter longint CP = 7
) (
  input  logic [3*N-1:0] x1_i,
  input  logic [N-1:0]   rd_i,
  output logic [4*N-1:0] x_o
);
  localparam int RW = 4 * N;
  logic [N-1:0]   d;
  logic [2*N-1:0] prod;
  logic [N-1:0]   q;

  assign d    = rd_i - x1_i[N-1:0];
  assign prod = (2*N)'(d) * (2*N)'(CP);
  assign q    = prod[N-1:0];
  assign x_o  = RW'(x1_i) + RW'(P) * RW'(q);
endmodule

// File: rtl/rns4_to_bin.sv
module rns4_to_bin #(
  parameter int N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [N-2:0]   res_a_i,
  input  logic [N:0]     res_b_i,
  input  logic [N-1:0]   res_c_i,
  input  logic [N-1:0]   res_d_i,
  output logic           valid_o,
  output logic [4*N-1:0] bin_o
);
  import rbc_pkg::*;
  localparam int     XW = 3 * N;
  localparam int     RW = 4 * N;
  localparam longint M1 = (longint'(1) << (N - 1)) - 1;
  localparam longint M2 = (longint'(1) << (N + 1)) - 1;
  localparam longint M3 = (longint'(1) << N) - 1;
  localparam longint M4 = longint'(1) << N;
  localparam longint P  = M1 * M2 * M3;
  localparam longint CP = mod_inv(P % M4, M4);

  if ((N % 2) != 0 || N < 4 || N > 16) begin : g_bad_n
    $error("rns4_to_bin: N must be even and within 4..16");
  end

  logic [XW-1:0] x1_c, x1_q;
  logic [N-1:0]  rd_q;
  logic          s1_vld_q;
  logic [RW-1:0] x_c;

  rbc_level1 #(.N(N)) u_lvl1 (
    .ra_i(res_a_i), .rb_i(res_b_i), .rc_i(res_c_i), .x1_o(x1_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      x1_q     <= '0;
      rd_q     <= '0;
    end else begin
      s1_vld_q <= valid_i;
      if (valid_i) begin
        x1_q <= x1_c;
        rd_q <= res_d_i;
      end
    end
  end

  rbc_level2 #(.N(N), .P(P), .CP(CP)) u_lvl2 (
    .x1_i(x1_q), .rd_i(rd_q), .x_o(x_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      bin_o   <= '0;
    end else begin
      valid_o <= s1_vld_q;
      if (s1_vld_q) bin_o <= x_c;
    end
  end
endmodule

// File: rtl/rns4_to_bin_chk.sv
module rns4_to_bin_chk #(
  parameter int N = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [N-2:0]   res_a_i,
  input logic [N:0]     res_b_i,
  input logic [N-1:0]   res_c_i,
  input logic [N-1:0]   res_d_i,
  input logic           valid_o,
  input logic [4*N-1:0] bin_o
);
  localparam longint M1 = (longint'(1) << (N - 1)) - 1;
  localparam longint M2 = (longint'(1) << (N + 1)) - 1;
  localparam longint M3 = (longint'(1) << N) - 1;
  localparam longint MT = M1 * M2 * M3 * (longint'(1) << N);

  p_lat_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  p_lat_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
  p_mod_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (longint'(bin_o) % M1) == (longint'($past(res_a_i, 2)) % M1));
  p_mod_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (longint'(bin_o) % M2) == (longint'($past(res_b_i, 2)) % M2));
  p_mod_c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (longint'(bin_o) % M3) == (longint'($past(res_c_i, 2)) % M3));
  p_low_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> bin_o[N-1:0] == $past(res_d_i, 2));
  p_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> longint'(bin_o) < MT);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(bin_o));
endmodule

bind rns4_to_bin rns4_to_bin_chk #(.N(N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .res_a_i(res_a_i), .res_b_i(res_b_i), .res_c_i(res_c_i), .res_d_i(res_d_i),
  .valid_o(valid_o), .bin_o(bin_o)
);

// File: tb/rns4_to_bin_tb_top.sv
`timescale 1ns/1ps
module rns4_to_bin_tb_top;
  localparam int     N = 4;
  localparam longint M = 52080;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [N-2:0]  res_a_i = '0;
  logic [N:0]    res_b_i = '0;
  logic [N-1:0]  res_c_i = '0;
  logic [N-1:0]  res_d_i = '0;
  logic          valid_o;
  logic [4*N-1:0] bin_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  rns4_to_bin #(.N(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .res_a_i(res_a_i), .res_b_i(res_b_i), .res_c_i(res_c_i), .res_d_i(res_d_i),
    .valid_o(valid_o), .bin_o(bin_o)
  );

  // columns: res_a, res_b, res_c, res_d, expected X
  localparam longint VEC [9][5] = '{
    '{0, 0, 0, 0, 0},
    '{1, 1, 1, 1, 1},
    '{6, 30, 14, 15, 52079},
    '{0, 0, 0, 7, 3255},
    '{4, 7, 0, 9, 12345},
    '{2, 10, 10, 0, 40000},
    '{7, 31, 15, 0, 0},
    '{7, 1, 1, 1, 7441},
    '{0, 31, 0, 5, 9765}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input longint a, input longint b, input longint c, input longint d);
    valid_i = 1'b1;
    res_a_i = (N-1)'(a);
    res_b_i = (N+1)'(b);
    res_c_i = N'(c);
    res_d_i = N'(d);
  endtask

  task automatic put_x(input longint x);
    put(x % 7, x % 31, x % 15, x % 16);
  endtask

  // Single sample with idle cycles around it.
  task automatic one_vec(input longint a, input longint b, input longint c,
                         input longint d, input longint exp, input string req);
    logic [4*N-1:0] held;
    @(negedge clk);
    put(a, b, c, d);
    @(negedge clk);
    valid_i = 1'b0;
    chk(valid_o == 1'b0, "R2 early", longint'(valid_o), 0);
    @(negedge clk);
    chk(valid_o == 1'b1, "R2 valid", longint'(valid_o), 1);
    chk(longint'(bin_o) == exp, req, longint'(bin_o), exp);
    held = bin_o;
    @(negedge clk);
    chk(valid_o == 1'b0 && bin_o == held, "R10 hold", longint'(bin_o), longint'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(valid_o == 1'b0 && bin_o == '0, "R1 in reset", longint'(bin_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0 && bin_o == '0, "R1 after release", longint'(bin_o), 0);

    // Table: R3 R4 R5 R6 R7 on plain vectors, R8 on all-ones zero encodings
    for (int i = 0; i < 9; i++) begin
      one_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
              (i >= 6) ? "R8 table" : "R3_R4_R5_R6_R7 table");
    end

    // R1: reset while a sample is in flight drops it
    @(negedge clk);
    put_x(12345);
    @(negedge clk);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    chk(valid_o == 1'b0 && bin_o == '0, "R1 flush", longint'(valid_o), 0);
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 flush later", longint'(valid_o), 0);

    // R9 + R11: exhaustive back-to-back sweep
    begin
      int bad;
      bad = 0;
      for (longint i = 0; i < M + 2; i++) begin
        @(negedge clk);
        if (i >= 2) begin
          checks++;
          if (!(valid_o == 1'b1 && longint'(bin_o) == i - 2)) begin
            failures++;
            bad++;
            if (bad <= 10)
              $display("FAIL R11 sweep actual=%0d expected=%0d valid=%0d", bin_o, i - 2, valid_o);
          end
        end
        if (i < M) put_x(i);
        else valid_i = 1'b0;
      end
      chk(bad == 0, "R9 back-to-back", bad, 0);
    end
    @(negedge clk);
    chk(valid_o == 1'b0 && longint'(bin_o) == M - 1, "R10 hold after sweep", longint'(bin_o), M - 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule